// File: doc/BRIEF.md
# Pipeline Data-Hazard and Operand-Forwarding Unit

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it compares the two source register numbers of the instruction in decode with the destinations of the two older instructions in flight: the one in execute and the one in the memory stage. From these matches it decides between two actions. It can take a newer operand value from one of those stages in place of the register-file read. It can also raise a stall request. The surrounding pipeline answers a stall by holding the program counter, throwing away the word fetched that cycle, and replacing the decode latch with a no-operation whose control signals are all deasserted.

A two-bit mode input picks one of three strategies. The first does nothing. The second stalls on every hazard. The third forwards wherever it can and stalls only when a load in execute has not yet produced its data. A producer's destination counts against the second source operand only when the producer itself reads a second register, that is, when it is a register-register instruction or a store. Register 0 never counts as a hazard. No check against writeback is needed, because the register file makes a write visible to a read in the same cycle. All outputs are combinational and valid in the same cycle as the inputs.

Top module: `hzd_unit`

## Requirements
- R1: A stage whose destination register number is 0 never causes a stall or a forward, even with its write enable set.
- R2: A stage whose write enable is low never causes a stall or a forward, whatever its destination.
- R3: A stage destination is always compared with the decode first source (`dec_rs_i`). It is compared with the decode second source (`dec_rt_i`) only when that stage's `*_rt_cmp_i` flag is 1.
- R4: With `mode_i` = 0 (off) or 3 (reserved, treated as off), `stall_o` is 0, both select outputs are 0, and both operand outputs equal the register-file values.
- R5: With `mode_i` = 1 (stall only), a hazard against execute or memory sets `stall_o`, and both selects stay 0.
- R6: With `mode_i` = 2 (forwarding), a hazard against an execute-stage instruction whose `ex_load_i` is 1 sets `stall_o`, and that stage's value is not selected.
- R7: With `mode_i` = 2, an execute hazard on an operand whose producer is not a load gives select code 1 and the `ex_alu_val_i` value on that operand, with no stall.
- R8: With `mode_i` = 2, a memory-stage hazard on an operand with no execute forward gives select code 2 and the `mem_wb_val_i` value. Memory-stage hazards never stall in this mode.
- R9: When both stages match the same operand in forwarding mode, the execute stage (select 1) wins.
- R10: Stall, selects and operand values follow the inputs in the same cycle, with no register in the path.
- R11: An operand with no forward (select code 0) outputs the register-file value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Hazard strategy: 0 off, 1 stall only, 2 forward, 3 off |
| dec_rs_i | input | AW | Decode first source register number |
| dec_rt_i | input | AW | Decode second source register number |
| dec_rs_val_i | input | DW | Register-file value read for the first source |
| dec_rt_val_i | input | DW | Register-file value read for the second source |
| ex_wr_en_i | input | 1 | Execute-stage instruction writes a register |
| ex_dst_i | input | AW | Execute-stage destination register number |
| ex_rt_cmp_i | input | 1 | Execute-stage instruction is register-register or a store |
| ex_load_i | input | 1 | Execute-stage instruction reads memory |
| ex_alu_val_i | input | DW | Execute-stage ALU result |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| mem_dst_i | input | AW | Memory-stage destination register number |
| mem_rt_cmp_i | input | 1 | Memory-stage instruction is register-register or a store |
| mem_wb_val_i | input | DW | Memory-stage final write-back value (load data or ALU result) |
| stall_o | output | 1 | Hold PC and fetch, bubble the decode latch |
| rs_src_o | output | 2 | First operand source: 0 register file, 1 execute, 2 memory |
| rt_src_o | output | 2 | Second operand source, same coding |
| rs_fwd_o | output | DW | First operand after forwarding |
| rt_fwd_o | output | DW | Second operand after forwarding |

## Verification
The hardest situation to reach is forwarding mode with both stages naming the same source register while the execute producer is a load. In that case the stall, the execute-over-memory priority and the second-source gating all act at once. Uniform random register numbers almost never line up three ways, so the random stimulus draws every register number from only four values and sets each write, load and second-source flag by coin toss. This makes multi-stage matches on both operands common. Directed cases then set up each priority and gating corner explicitly, including destination 0 with write enabled.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [1:0] {
      HZ_OFF   = 2'd0,
      HZ_STALL = 2'd1,
      HZ_FWD   = 2'd2,
      HZ_RSVD  = 2'd3
   } hz_mode_e;

   typedef enum logic [1:0] {
      SRC_RF  = 2'd0,
      SRC_EXE = 2'd1,
      SRC_MEM = 2'd2
   } op_src_e;

   localparam int unsigned N_STAGE = 2;
   localparam int unsigned STG_EXE = 0;
   localparam int unsigned STG_MEM = 1;

   localparam int unsigned N_OPND  = 2;
   localparam int unsigned OPND_RS = 0;
   localparam int unsigned OPND_RT = 1;

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
   parameter int unsigned AW = 5
) (
   input  logic          wr_en_i,
   input  logic [AW-1:0] dst_i,
   input  logic          rt_cmp_i,
   input  logic [AW-1:0] rs_i,
   input  logic [AW-1:0] rt_i,
   output logic          rs_hit_o,
   output logic          rt_hit_o
);
   logic live;

   // register 0 absorbs writes, so it never produces a dependency
   assign live     = wr_en_i && (dst_i != '0);
   assign rs_hit_o = live && (dst_i == rs_i);
   assign rt_hit_o = live && rt_cmp_i && (dst_i == rt_i);
endmodule

// File: rtl/hzd_policy.sv
module hzd_policy
   import hzd_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       ex_hit_i,
   input  logic       mem_hit_i,
   input  logic       ex_load_i,
   output logic       stall_o,
   output logic       fwd_en_o
);
   always_comb begin
      stall_o  = 1'b0;
      fwd_en_o = 1'b0;
      case (hz_mode_e'(mode_i))
         HZ_STALL: stall_o = ex_hit_i || mem_hit_i;
         HZ_FWD: begin
            fwd_en_o = 1'b1;
            stall_o  = ex_hit_i && ex_load_i;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/hzd_opsel.sv
module hzd_opsel
   import hzd_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          fwd_en_i,
   input  logic          ex_hit_i,
   input  logic          ex_load_i,
   input  logic          mem_hit_i,
   input  logic [DW-1:0] rf_val_i,
   input  logic [DW-1:0] ex_val_i,
   input  logic [DW-1:0] mem_val_i,
   output logic [1:0]    sel_o,
   output logic [DW-1:0] val_o
);
   op_src_e src;

   // newest producer first; a load in execute has no data yet
   always_comb begin
      if (fwd_en_i && ex_hit_i && !ex_load_i) src = SRC_EXE;
      else if (fwd_en_i && mem_hit_i)          src = SRC_MEM;
      else                                      src = SRC_RF;
   end

   always_comb begin
      case (src)
         SRC_EXE: val_o = ex_val_i;
         SRC_MEM: val_o = mem_val_i;
         default: val_o = rf_val_i;
      endcase
   end

   assign sel_o = src;
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
   import hzd_pkg::*;
#(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 32
) (
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] dec_rs_i,
   input  logic [AW-1:0] dec_rt_i,
   input  logic [DW-1:0] dec_rs_val_i,
   input  logic [DW-1:0] dec_rt_val_i,
   input  logic          ex_wr_en_i,
   input  logic [AW-1:0] ex_dst_i,
   input  logic          ex_rt_cmp_i,
   input  logic          ex_load_i,
   input  logic [DW-1:0] ex_alu_val_i,
   input  logic          mem_wr_en_i,
   input  logic [AW-1:0] mem_dst_i,
   input  logic          mem_rt_cmp_i,
   input  logic [DW-1:0] mem_wb_val_i,
   output logic          stall_o,
   output logic [1:0]    rs_src_o,
   output logic [1:0]    rt_src_o,
   output logic [DW-1:0] rs_fwd_o,
   output logic [DW-1:0] rt_fwd_o
);
   localparam int unsigned NS = N_STAGE;
   localparam int unsigned NO = N_OPND;

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("hzd_unit: AW must lie in 1..8");
   end
   if (DW < 1) begin : g_bad_dw
      $error("hzd_unit: DW must be at least 1");
   end

   // per-stage producer view, indexed by STG_*
   logic [NS-1:0] stg_wr, stg_rtc, rs_hit, rt_hit;
   logic [AW-1:0] stg_dst [NS];

   assign stg_wr[STG_EXE]  = ex_wr_en_i;
   assign stg_wr[STG_MEM]  = mem_wr_en_i;
   assign stg_rtc[STG_EXE] = ex_rt_cmp_i;
   assign stg_rtc[STG_MEM] = mem_rt_cmp_i;
   assign stg_dst[STG_EXE] = ex_dst_i;
   assign stg_dst[STG_MEM] = mem_dst_i;

   for (genvar s = 0; s < NS; s++) begin : g_stage
      hzd_match #(.AW(AW)) u_match (
         .wr_en_i  (stg_wr[s]),
         .dst_i    (stg_dst[s]),
         .rt_cmp_i (stg_rtc[s]),
         .rs_i     (dec_rs_i),
         .rt_i     (dec_rt_i),
         .rs_hit_o (rs_hit[s]),
         .rt_hit_o (rt_hit[s])
      );
   end

   logic fwd_en;

   hzd_policy u_policy (
      .mode_i    (mode_i),
      .ex_hit_i  (rs_hit[STG_EXE] | rt_hit[STG_EXE]),
      .mem_hit_i (rs_hit[STG_MEM] | rt_hit[STG_MEM]),
      .ex_load_i (ex_load_i),
      .stall_o   (stall_o),
      .fwd_en_o  (fwd_en)
   );

   // per-operand view, indexed by OPND_*
   logic [NO-1:0] op_ex_hit, op_mem_hit;
   logic [DW-1:0] op_rf  [NO];
   logic [DW-1:0] op_val [NO];
   logic [1:0]    op_sel [NO];

   assign op_ex_hit[OPND_RS]  = rs_hit[STG_EXE];
   assign op_ex_hit[OPND_RT]  = rt_hit[STG_EXE];
   assign op_mem_hit[OPND_RS] = rs_hit[STG_MEM];
   assign op_mem_hit[OPND_RT] = rt_hit[STG_MEM];
   assign op_rf[OPND_RS]      = dec_rs_val_i;
   assign op_rf[OPND_RT]      = dec_rt_val_i;

   for (genvar o = 0; o < NO; o++) begin : g_opnd
      hzd_opsel #(.DW(DW)) u_opsel (
         .fwd_en_i  (fwd_en),
         .ex_hit_i  (op_ex_hit[o]),
         .ex_load_i (ex_load_i),
         .mem_hit_i (op_mem_hit[o]),
         .rf_val_i  (op_rf[o]),
         .ex_val_i  (ex_alu_val_i),
         .mem_val_i (mem_wb_val_i),
         .sel_o     (op_sel[o]),
         .val_o     (op_val[o])
      );
   end

   assign rs_src_o = op_sel[OPND_RS];
   assign rt_src_o = op_sel[OPND_RT];
   assign rs_fwd_o = op_val[OPND_RS];
   assign rt_fwd_o = op_val[OPND_RT];
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 32
) (
   input logic [1:0]    mode_i,
   input logic [AW-1:0] dec_rs_i,
   input logic [AW-1:0] dec_rt_i,
   input logic [DW-1:0] dec_rs_val_i,
   input logic [DW-1:0] dec_rt_val_i,
   input logic          ex_wr_en_i,
   input logic [AW-1:0] ex_dst_i,
   input logic          ex_rt_cmp_i,
   input logic          ex_load_i,
   input logic [DW-1:0] ex_alu_val_i,
   input logic          mem_wr_en_i,
   input logic [AW-1:0] mem_dst_i,
   input logic          mem_rt_cmp_i,
   input logic [DW-1:0] mem_wb_val_i,
   input logic          stall_o,
   input logic [1:0]    rs_src_o,
   input logic [1:0]    rt_src_o,
   input logic [DW-1:0] rs_fwd_o,
   input logic [DW-1:0] rt_fwd_o
);
   logic ex_live, mem_live;
   assign ex_live  = ex_wr_en_i && (ex_dst_i != '0);
   assign mem_live = mem_wr_en_i && (mem_dst_i != '0);

   always_comb begin
      if (mode_i == 2'd0 || mode_i == 2'd3)
         p_off_quiet_r4: assert (!stall_o && rs_src_o == 2'd0 && rt_src_o == 2'd0
                                 && rs_fwd_o == dec_rs_val_i && rt_fwd_o == dec_rt_val_i)
            else $error("off mode produced an action");
      if (mode_i == 2'd1)
         p_stall_only_sel_r5: assert (rs_src_o == 2'd0 && rt_src_o == 2'd0)
            else $error("stall-only mode forwarded");
      // R2 as well: no live destination means no action at all
      if (!ex_live && !mem_live)
         p_dead_dst_r1: assert (!stall_o && rs_src_o == 2'd0 && rt_src_o == 2'd0)
            else $error("action without a live destination");
      if (rs_src_o == 2'd1)
         p_exe_rs_r7: assert (rs_fwd_o == ex_alu_val_i && ex_dst_i == dec_rs_i && !ex_load_i)
            else $error("bad execute forward on first operand");
      if (rs_src_o == 2'd2)
         p_mem_rs_r8: assert (rs_fwd_o == mem_wb_val_i && mem_dst_i == dec_rs_i)
            else $error("bad memory forward on first operand");
      if (rt_src_o == 2'd1)
         p_exe_rt_gate_r3: assert (ex_rt_cmp_i && ex_dst_i == dec_rt_i && rt_fwd_o == ex_alu_val_i)
            else $error("second operand forwarded from execute without gating");
      if (rt_src_o == 2'd2)
         p_mem_rt_gate_r3: assert (mem_rt_cmp_i && mem_dst_i == dec_rt_i && rt_fwd_o == mem_wb_val_i)
            else $error("second operand forwarded from memory without gating");
      if (mode_i == 2'd2 && !(ex_live && ex_load_i))
         p_fwd_no_stall_r8: assert (!stall_o)
            else $error("forwarding mode stalled without an execute load");
      if (rs_src_o == 2'd0)
         p_rf_pass_r11: assert (rs_fwd_o == dec_rs_val_i)
            else $error("unforwarded first operand altered");
   end
endmodule

bind hzd_unit hzd_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/hzd_unit_test.sv
`timescale 1ns/1ps
module hzd_unit_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0]  mode_i;
   logic [4:0]  dec_rs_i, dec_rt_i, ex_dst_i, mem_dst_i;
   logic [31:0] dec_rs_val_i, dec_rt_val_i, ex_alu_val_i, mem_wb_val_i;
   logic        ex_wr_en_i, ex_rt_cmp_i, ex_load_i, mem_wr_en_i, mem_rt_cmp_i;
   logic        stall_o;
   logic [1:0]  rs_src_o, rt_src_o;
   logic [31:0] rs_fwd_o, rt_fwd_o;

   hzd_unit uut (.*);

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // expected outputs, written from the requirements
   task automatic predict(output logic st, output logic [1:0] ss, output logic [1:0] ts,
                          output logic [31:0] sv, output logic [31:0] tv);
      logic el, ml, ers, ert, mrs, mrt, fwd;
      el  = ex_wr_en_i && ex_dst_i != 0;
      ml  = mem_wr_en_i && mem_dst_i != 0;
      ers = el && ex_dst_i == dec_rs_i;
      ert = el && ex_rt_cmp_i && ex_dst_i == dec_rt_i;
      mrs = ml && mem_dst_i == dec_rs_i;
      mrt = ml && mem_rt_cmp_i && mem_dst_i == dec_rt_i;
      fwd = (mode_i == 2'd2);
      case (mode_i)
         2'd1:    st = ers | ert | mrs | mrt;
         2'd2:    st = (ers | ert) & ex_load_i;
         default: st = 1'b0;
      endcase
      ss = (fwd && ers && !ex_load_i) ? 2'd1 : (fwd && mrs) ? 2'd2 : 2'd0;
      ts = (fwd && ert && !ex_load_i) ? 2'd1 : (fwd && mrt) ? 2'd2 : 2'd0;
      sv = ss == 2'd1 ? ex_alu_val_i : ss == 2'd2 ? mem_wb_val_i : dec_rs_val_i;
      tv = ts == 2'd1 ? ex_alu_val_i : ts == 2'd2 ? mem_wb_val_i : dec_rt_val_i;
   endtask

   task automatic check_all(string tag);
      logic st; logic [1:0] ss, ts; logic [31:0] sv, tv;
      predict(st, ss, ts, sv, tv);
      check({tag, " stall"}, 32'(stall_o), 32'(st));
      check({tag, " rs_src"}, 32'(rs_src_o), 32'(ss));
      check({tag, " rt_src"}, 32'(rt_src_o), 32'(ts));
      check({tag, " rs_val"}, rs_fwd_o, sv);
      check({tag, " rt_val"}, rt_fwd_o, tv);
   endtask

   task automatic step(string tag);
      @(negedge clk);
      check_all(tag);
      @(posedge clk);
      #1;
   endtask

   task automatic quiet(logic [1:0] m);
      mode_i = m;
      dec_rs_i = 5'd3; dec_rt_i = 5'd4;
      dec_rs_val_i = 32'h1111_0003; dec_rt_val_i = 32'h2222_0004;
      ex_wr_en_i = 0; ex_dst_i = 0; ex_rt_cmp_i = 0; ex_load_i = 0;
      ex_alu_val_i = 32'hEEEE_0001;
      mem_wr_en_i = 0; mem_dst_i = 0; mem_rt_cmp_i = 0;
      mem_wb_val_i = 32'hAAAA_0002;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      quiet(2'd2);
      repeat (3) @(posedge clk);
      #1;
      // reset state: idle stages, no action (R2)
      step("R2 reset idle");
      rst_n = 1'b1;

      // R1: destination 0 with write enabled, matching rs = 0
      quiet(2'd2); dec_rs_i = 0; ex_wr_en_i = 1; ex_dst_i = 0; mem_wr_en_i = 1; mem_dst_i = 0;
      step("R1 zero dst");
      check("R1 zero dst no stall", 32'(stall_o), 0);

      // R2: write disabled, matching destination, stall mode
      quiet(2'd1); ex_dst_i = 5'd3; mem_dst_i = 5'd4; mem_rt_cmp_i = 1;
      step("R2 no write");
      check("R2 no write stall", 32'(stall_o), 0);

      // R3: rt match gated by producer flag
      quiet(2'd1); ex_wr_en_i = 1; ex_dst_i = 5'd4; ex_rt_cmp_i = 0;
      step("R3 rt gated off");
      check("R3 rt gated off stall", 32'(stall_o), 0);
      ex_rt_cmp_i = 1;
      step("R3 rt gated on");
      check("R3 rt gated on stall", 32'(stall_o), 1);
      // rs compared regardless of the flag
      quiet(2'd1); mem_wr_en_i = 1; mem_dst_i = 5'd3;
      step("R3 rs always");
      check("R3 rs always stall", 32'(stall_o), 1);

      // R4: off and reserved modes with hazards on both stages
      quiet(2'd0); ex_wr_en_i = 1; ex_dst_i = 5'd3; mem_wr_en_i = 1; mem_dst_i = 5'd4; mem_rt_cmp_i = 1;
      step("R4 mode off");
      check("R4 mode off rs", rs_fwd_o, 32'h1111_0003);
      mode_i = 2'd3;
      step("R4 mode rsvd");
      check("R4 mode rsvd stall", 32'(stall_o), 0);

      // R5: stall-only, memory hazard alone
      quiet(2'd1); mem_wr_en_i = 1; mem_dst_i = 5'd3;
      step("R5 mem stall");
      check("R5 mem stall sel", 32'(rs_src_o), 0);

      // R6: forwarding, execute load on rs
      quiet(2'd2); ex_wr_en_i = 1; ex_dst_i = 5'd3; ex_load_i = 1;
      step("R6 load use");
      check("R6 load use stall", 32'(stall_o), 1);
      check("R6 load use sel", 32'(rs_src_o), 0);

      // R7: forwarding from execute on rt
      quiet(2'd2); ex_wr_en_i = 1; ex_dst_i = 5'd4; ex_rt_cmp_i = 1;
      step("R7 exe rt");
      check("R7 exe rt sel", 32'(rt_src_o), 1);
      check("R7 exe rt val", rt_fwd_o, 32'hEEEE_0001);

      // R8: forwarding from memory, execute load elsewhere does not matter
      quiet(2'd2); mem_wr_en_i = 1; mem_dst_i = 5'd3; ex_wr_en_i = 1; ex_dst_i = 5'd9; ex_load_i = 1;
      step("R8 mem rs");
      check("R8 mem rs sel", 32'(rs_src_o), 2);
      check("R8 mem rs val", rs_fwd_o, 32'hAAAA_0002);
      check("R8 mem no stall", 32'(stall_o), 0);

      // R9: both stages on rs, execute wins
      quiet(2'd2); ex_wr_en_i = 1; ex_dst_i = 5'd3; mem_wr_en_i = 1; mem_dst_i = 5'd3;
      step("R9 priority");
      check("R9 priority sel", 32'(rs_src_o), 1);

      // R10: same-cycle response, no clock edge between change and sample
      quiet(2'd2); ex_wr_en_i = 1; ex_dst_i = 5'd3;
      #1;
      check("R10 comb sel", 32'(rs_src_o), 1);
      dec_rs_i = 5'd7;
      #1;
      check("R10 comb release", 32'(rs_src_o), 0);
      // R11: unforwarded operand passes through
      check("R11 pass rs", rs_fwd_o, 32'h1111_0003);
      @(posedge clk);
      #1;

      // random mix over a small register space
      for (int i = 0; i < 600; i++) begin
         mode_i = 2'($urandom_range(0, 3));
         dec_rs_i = 5'($urandom_range(0, 3));
         dec_rt_i = 5'($urandom_range(0, 3));
         ex_dst_i = 5'($urandom_range(0, 3));
         mem_dst_i = 5'($urandom_range(0, 3));
         ex_wr_en_i = 1'($urandom); ex_rt_cmp_i = 1'($urandom); ex_load_i = 1'($urandom);
         mem_wr_en_i = 1'($urandom); mem_rt_cmp_i = 1'($urandom);
         dec_rs_val_i = $urandom; dec_rt_val_i = $urandom;
         ex_alu_val_i = $urandom; mem_wb_val_i = $urandom;
         step("random R3 R5 R6 R7 R8 R9");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule